// File: doc/BRIEF.md
# Three-Level Programming Pulse Classifier

This block watches one multiplexed pin that is driven to three voltage bands: a low idle band, a mid band and a high band. Two external comparators turn the pin voltage into two digital bits, one above the mid threshold and one above the high threshold. The block brings both bits into its clock domain, removes single-sample glitches, and times every excursion out of the low band as well as every low gap between excursions. When an excursion ends and the pin is back in the low band, the block issues exactly one one-clock verdict: a mid selection pulse, a high selection pulse, a long high fuse-blow pulse, or a rejected pulse.

A downstream programming sequencer consumes the strobes as clean protocol tokens. It does not need to know anything about the comparator timing, because all width limits are set in microseconds and turned into clock cycles from the clock frequency parameter when the block is elaborated.

Top module: `lvl_pulse_classifier`

## Requirements
- R1: After reset, all four strobes are low. The low-gap timer starts from zero at reset, so a pulse that begins less than the minimum gap (20 µs, `GAP_MIN_US`) after reset is rejected on `ev_err`.
- R2: A pulse that stays above the mid threshold and never crosses the high threshold, with an active width of at least 20 µs (`ACT_MIN_US`), produces one `ev_mid` strobe. Mid pulses have no upper width limit.
- R3: A pulse that crosses the high threshold at any point, with an active width from 20 µs up to but not including 90 µs (`BLOW_MIN_US`), produces one `ev_high` strobe. This includes a pulse that first sits in the mid band and later rises to the high band.
- R4: A high pulse with an active width from 90 µs to 100 µs inclusive (`BLOW_MAX_US`) produces one `ev_blow` strobe and no `ev_high` strobe.
- R5: A high pulse longer than 100 µs produces `ev_err` and no other event.
- R6: A pulse whose filtered active width is at least 2 cycles but less than 20 µs produces `ev_err` and no other event.
- R7: A pulse preceded by fewer than 20 µs of low time produces `ev_err`. A gap of exactly the minimum is accepted.
- R8: A pulse during which the high comparator bit is 1 while the mid comparator bit is 0 is a level violation and produces `ev_err` only.
- R9: An input spike lasting one clock on either comparator bit is ignored. It produces no strobe and does not restart the low-gap timer.
- R10: Each pulse produces at most one of `ev_mid`, `ev_high`, `ev_blow` and `ev_err`. That strobe lasts one clock and appears only after the filtered pin has returned to low, within 8 clocks of the raw fall.
- R11: Widths are measured in clock cycles: a threshold of T µs equals T × (`CLK_HZ` / 1,000,000) cycles. Both edges pass through the same synchronizer and filter delay, so the raw width in cycles equals the measured width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| cmp_mid | input | 1 | Asynchronous comparator bit, 1 when the pin is above the mid threshold |
| cmp_high | input | 1 | Asynchronous comparator bit, 1 when the pin is above the high threshold |
| ev_mid | output | 1 | One-clock strobe for an accepted mid pulse |
| ev_high | output | 1 | One-clock strobe for an accepted high selection pulse |
| ev_blow | output | 1 | One-clock strobe for an accepted fuse-blow pulse |
| ev_err | output | 1 | One-clock strobe for a rejected pulse |

## Verification
The bench drives each width limit on both sides of the limit. It uses the minimum active width and one cycle less, the last high width before the blow window, both ends of the blow window, and one cycle past it. A comparison that is off by one, or that uses the wrong operator, turns a mid or high verdict into an error, or a blow verdict into a high verdict or an error. The gap limit is tested the same way, at exactly the minimum and one cycle short of it. Another case splits a long gap with a one-cycle spike: a filter that lets the spike through restarts the gap timer, and the valid pulse that follows is then rejected. Mid-to-high pulses and high-without-mid pulses check that the high flag and the level-violation flag are both kept for the whole pulse. Random pulse shapes then check at the ports that every pulse yields exactly one strobe and that each strobe lasts one clock.

// File: rtl/lvlp_pkg.sv
package lvlp_pkg;

   typedef enum logic [2:0] {
      PR_NONE,
      PR_MID,
      PR_HIGH,
      PR_BLOW,
      PR_ERR
   } pulse_res_e;

   // Microseconds to clock cycles for an integral-MHz clock.
   function automatic int unsigned us_to_cyc(input int unsigned clk_hz,
                                             input int unsigned us);
      return (clk_hz / 1_000_000) * us;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/lvlp_sync_filter.sv
module lvlp_sync_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TAPS        = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_raw,
   output logic q_filt
);

   localparam int unsigned HALF = TAPS / 2;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   sync_out;

   always_ff @(posedge clk) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], d_raw};
   end

   assign sync_out = sync_q[SYNC_STAGES-1];

   generate
      if (TAPS == 1) begin : g_bypass
         always_ff @(posedge clk) begin
            if (!rst_n) q_filt <= 1'b0;
            else        q_filt <= sync_out;
         end
      end else begin : g_majority
         logic [TAPS-1:0] hist;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hist   <= '0;
               q_filt <= 1'b0;
            end else begin
               hist   <= {hist[TAPS-2:0], sync_out};
               q_filt <= ($countones(hist) > HALF);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/lvlp_span_timer.sv
module lvlp_span_timer #(
   parameter int unsigned CNT_W   = 10,
   parameter int unsigned ACT_SAT = 401,
   parameter int unsigned GAP_SAT = 80
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_act,
   output logic             rise,
   output logic             fall,
   output logic [CNT_W-1:0] act_cnt,
   output logic [CNT_W-1:0] gap_cnt
);

   localparam logic [CNT_W-1:0] ACT_TOP = CNT_W'(ACT_SAT);
   localparam logic [CNT_W-1:0] GAP_TOP = CNT_W'(GAP_SAT);
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

   logic prev_act;

   assign rise = pin_act & ~prev_act;
   assign fall = ~pin_act & prev_act;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_act <= 1'b0;
      else        prev_act <= pin_act;
   end

   // Active width: restarts at each rise, holds after the fall until next rise.
   always_ff @(posedge clk) begin
      if (!rst_n)                           act_cnt <= '0;
      else if (rise)                        act_cnt <= ONE;
      else if (pin_act && act_cnt < ACT_TOP) act_cnt <= act_cnt + ONE;
   end

   // Low gap: cleared while active, saturates at the minimum gap.
   always_ff @(posedge clk) begin
      if (!rst_n)                            gap_cnt <= '0;
      else if (pin_act)                      gap_cnt <= '0;
      else if (gap_cnt < GAP_TOP)            gap_cnt <= gap_cnt + ONE;
   end

   // R11
   cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_cnt <= ACT_TOP) && (gap_cnt <= GAP_TOP));

   // R11
   act_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_act && !rise && act_cnt < ACT_TOP) |=> (act_cnt == $past(act_cnt) + ONE));

endmodule

// File: rtl/lvlp_judge.sv
module lvlp_judge #(
   parameter int unsigned CNT_W    = 10,
   parameter int unsigned MIN_ACT  = 80,
   parameter int unsigned MIN_GAP  = 80,
   parameter int unsigned BLOW_MIN = 360,
   parameter int unsigned BLOW_MAX = 400
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mid_f,
   input  logic             high_f,
   input  logic             pin_act,
   input  logic             rise,
   input  logic             fall,
   input  logic [CNT_W-1:0] act_cnt,
   input  logic [CNT_W-1:0] gap_cnt,
   output logic             ev_mid,
   output logic             ev_high,
   output logic             ev_blow,
   output logic             ev_err
);
   import lvlp_pkg::*;

   localparam logic [CNT_W-1:0] ACT_LIM = CNT_W'(MIN_ACT);
   localparam logic [CNT_W-1:0] GAP_LIM = CNT_W'(MIN_GAP);
   localparam logic [CNT_W-1:0] BLOW_LO = CNT_W'(BLOW_MIN);
   localparam logic [CNT_W-1:0] BLOW_HI = CNT_W'(BLOW_MAX);

   logic       gap_bad_q;
   logic       lvl_bad_q;
   logic       hi_q;
   logic       lvl_now;
   pulse_res_e res;

   assign lvl_now = high_f & ~mid_f;

   // Per-pulse flags: loaded at the rise, accumulated while active.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_bad_q <= 1'b0;
         lvl_bad_q <= 1'b0;
         hi_q      <= 1'b0;
      end else if (rise) begin
         gap_bad_q <= (gap_cnt < GAP_LIM);
         lvl_bad_q <= lvl_now;
         hi_q      <= high_f;
      end else if (pin_act) begin
         lvl_bad_q <= lvl_bad_q | lvl_now;
         hi_q      <= hi_q | high_f;
      end
   end

   always_comb begin
      res = PR_NONE;
      if (fall) begin
         if (gap_bad_q || lvl_bad_q || act_cnt < ACT_LIM) res = PR_ERR;
         else if (!hi_q)                                  res = PR_MID;
         else if (act_cnt < BLOW_LO)                      res = PR_HIGH;
         else if (act_cnt <= BLOW_HI)                     res = PR_BLOW;
         else                                             res = PR_ERR;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ev_mid  <= 1'b0;
         ev_high <= 1'b0;
         ev_blow <= 1'b0;
         ev_err  <= 1'b0;
      end else begin
         ev_mid  <= (res == PR_MID);
         ev_high <= (res == PR_HIGH);
         ev_blow <= (res == PR_BLOW);
         ev_err  <= (res == PR_ERR);
      end
   end

   // R10
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev_mid, ev_high, ev_blow, ev_err}));

   // R10
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_mid | ev_high | ev_blow | ev_err) |=> !(ev_mid | ev_high | ev_blow | ev_err));

   // R10
   ev_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_mid | ev_high | ev_blow | ev_err) |-> $past(!pin_act));

   // R4
   blow_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_blow |-> ($past(act_cnt) >= BLOW_LO && $past(act_cnt) <= BLOW_HI));

   // R2
   mid_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_mid |-> ($past(act_cnt) >= ACT_LIM));

endmodule

// File: rtl/lvl_pulse_classifier.sv
module lvl_pulse_classifier #(
   parameter int unsigned CLK_HZ      = 125_000_000,
   parameter int unsigned ACT_MIN_US  = 20,
   parameter int unsigned GAP_MIN_US  = 20,
   parameter int unsigned BLOW_MIN_US = 90,
   parameter int unsigned BLOW_MAX_US = 100,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_TAPS   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmp_mid,
   input  logic cmp_high,
   output logic ev_mid,
   output logic ev_high,
   output logic ev_blow,
   output logic ev_err
);
   import lvlp_pkg::*;

   localparam int unsigned MIN_ACT  = us_to_cyc(CLK_HZ, ACT_MIN_US);
   localparam int unsigned MIN_GAP  = us_to_cyc(CLK_HZ, GAP_MIN_US);
   localparam int unsigned BLOW_MIN = us_to_cyc(CLK_HZ, BLOW_MIN_US);
   localparam int unsigned BLOW_MAX = us_to_cyc(CLK_HZ, BLOW_MAX_US);
   localparam int unsigned ACT_SAT  = BLOW_MAX + 1;
   localparam int unsigned GAP_SAT  = MIN_GAP;
   localparam int unsigned CNT_W    = $clog2(max2(ACT_SAT, GAP_SAT) + 1);
   localparam int unsigned NBITS    = 2;

   generate
      if (CLK_HZ < 1_000_000 || (CLK_HZ % 1_000_000) != 0) begin : g_bad_clk
         $error("CLK_HZ must be a whole number of MHz");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (FILT_TAPS % 2 == 0) begin : g_bad_taps
         $error("FILT_TAPS must be odd");
      end
      if (MIN_ACT < 2 || BLOW_MIN <= MIN_ACT || BLOW_MAX < BLOW_MIN) begin : g_bad_win
         $error("width limits must satisfy 2 <= min < blow_min <= blow_max");
      end
   endgenerate

   logic [NBITS-1:0] raw_bits;
   logic [NBITS-1:0] filt_bits;
   logic             mid_f;
   logic             high_f;
   logic             pin_act;
   logic             rise;
   logic             fall;
   logic [CNT_W-1:0] act_cnt;
   logic [CNT_W-1:0] gap_cnt;

   assign raw_bits = {cmp_high, cmp_mid};

   generate
      for (genvar b = 0; b < NBITS; b++) begin : g_in
         lvlp_sync_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .TAPS       (FILT_TAPS)
         ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .d_raw (raw_bits[b]),
            .q_filt(filt_bits[b])
         );
      end
   endgenerate

   assign mid_f   = filt_bits[0];
   assign high_f  = filt_bits[1];
   assign pin_act = mid_f | high_f;

   lvlp_span_timer #(
      .CNT_W  (CNT_W),
      .ACT_SAT(ACT_SAT),
      .GAP_SAT(GAP_SAT)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_act(pin_act),
      .rise   (rise),
      .fall   (fall),
      .act_cnt(act_cnt),
      .gap_cnt(gap_cnt)
   );

   lvlp_judge #(
      .CNT_W   (CNT_W),
      .MIN_ACT (MIN_ACT),
      .MIN_GAP (MIN_GAP),
      .BLOW_MIN(BLOW_MIN),
      .BLOW_MAX(BLOW_MAX)
   ) u_judge (
      .clk    (clk),
      .rst_n  (rst_n),
      .mid_f  (mid_f),
      .high_f (high_f),
      .pin_act(pin_act),
      .rise   (rise),
      .fall   (fall),
      .act_cnt(act_cnt),
      .gap_cnt(gap_cnt),
      .ev_mid (ev_mid),
      .ev_high(ev_high),
      .ev_blow(ev_blow),
      .ev_err (ev_err)
   );

   // R9
   glitch_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pin_act) |=> pin_act);

endmodule

// File: tb/lvl_pulse_classifier_tb.sv
module lvl_pulse_classifier_tb;

   // 4 MHz timing basis: thresholds in cycles (R11).
   localparam int unsigned TB_HZ  = 4_000_000;
   localparam int ACT_C  = 20 * 4;
   localparam int GAP_C  = 20 * 4;
   localparam int BMIN_C = 90 * 4;
   localparam int BMAX_C = 100 * 4;

   localparam int C_NONE = 0;
   localparam int C_MID  = 1;
   localparam int C_HIGH = 2;
   localparam int C_BLOW = 3;
   localparam int C_ERR  = 4;

   // pulse kinds
   localparam int K_MID  = 0;
   localparam int K_HIGH = 1;
   localparam int K_STEP = 2;
   localparam int K_VIOL = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmp_mid = 1'b0;
   logic cmp_high = 1'b0;
   logic ev_mid, ev_high, ev_blow, ev_err;

   always #4 clk = ~clk;

   lvl_pulse_classifier #(.CLK_HZ(TB_HZ)) u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmp_mid (cmp_mid),
      .cmp_high(cmp_high),
      .ev_mid  (ev_mid),
      .ev_high (ev_high),
      .ev_blow (ev_blow),
      .ev_err  (ev_err)
   );

   int n_chk = 0;
   int n_err = 0;
   int cnt_mid = 0, cnt_high = 0, cnt_blow = 0, cnt_err = 0;
   int dbl = 0, during = 0;
   bit prev_any = 1'b0;
   bit in_pulse = 1'b0;
   bit done = 1'b0;
   int last_gap = 0;

   always @(negedge clk) begin
      automatic bit any = ev_mid | ev_high | ev_blow | ev_err;
      cnt_mid  += int'(ev_mid);
      cnt_high += int'(ev_high);
      cnt_blow += int'(ev_blow);
      cnt_err  += int'(ev_err);
      if (any && prev_any) dbl++;
      if (any && in_pulse) during++;
      prev_any = any;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_code(input int kind, input int w, input int gap);
      if (w < 2)        return C_NONE;
      if (kind == K_VIOL) return C_ERR;
      if (gap < GAP_C)  return C_ERR;
      if (w < ACT_C)    return C_ERR;
      if (kind == K_MID) return C_MID;
      if (w < BMIN_C)   return C_HIGH;
      if (w <= BMAX_C)  return C_BLOW;
      return C_ERR;
   endfunction

   function automatic int pack_cnt(input int m, input int h, input int b, input int e);
      return m * 1000 + h * 100 + b * 10 + e;
   endfunction

   function automatic int code_to_pack(input int c);
      case (c)
         C_MID:   return 1000;
         C_HIGH:  return 100;
         C_BLOW:  return 10;
         C_ERR:   return 1;
         default: return 0;
      endcase
   endfunction

   // Drive one excursion of w cycles, then tail low cycles, then check.
   task automatic do_pulse(input int kind, input int w, input int tail, input string req);
      int m0, h0, b0, e0, exp, got, gap_in;
      m0 = cnt_mid; h0 = cnt_high; b0 = cnt_blow; e0 = cnt_err;
      gap_in = last_gap;
      exp = exp_code(kind, w, gap_in);
      @(negedge clk);
      in_pulse = 1'b1;
      for (int i = 0; i < w; i++) begin
         case (kind)
            K_MID:  begin cmp_mid = 1'b1; cmp_high = 1'b0; end
            K_HIGH: begin cmp_mid = 1'b1; cmp_high = 1'b1; end
            K_STEP: begin cmp_mid = 1'b1; cmp_high = (i >= w / 2); end
            default: begin cmp_mid = 1'b0; cmp_high = 1'b1; end
         endcase
         @(negedge clk);
      end
      cmp_mid = 1'b0;
      cmp_high = 1'b0;
      in_pulse = 1'b0;
      repeat (tail - 1) @(negedge clk);
      if (w < 2) last_gap = gap_in + w + tail;
      else       last_gap = tail;
      got = pack_cnt(cnt_mid - m0, cnt_high - h0, cnt_blow - b0, cnt_err - e0);
      chk(got == code_to_pack(exp), req, got, code_to_pack(exp));
   endtask

   initial begin
      void'($urandom(32'h1A5E_0C3D));
      repeat (6) @(negedge clk);
      // R1: no strobe while in reset
      chk(cnt_mid + cnt_high + cnt_blow + cnt_err == 0, "R1 reset quiet", cnt_mid + cnt_high + cnt_blow + cnt_err, 0);
      rst_n = 1'b1;
      repeat (29) @(negedge clk);
      chk(cnt_mid + cnt_high + cnt_blow + cnt_err == 0, "R1 idle after reset", cnt_mid + cnt_high + cnt_blow + cnt_err, 0);
      last_gap = 30;
      // R1 / R7: pulse too soon after reset
      do_pulse(K_MID, 100, 100, "R1 early pulse rejected");
      // R2 boundary and long mid
      do_pulse(K_MID, ACT_C, 80, "R2 mid at min width");
      do_pulse(K_MID, 1000, 100, "R2 long mid");
      // R6
      do_pulse(K_MID, ACT_C - 1, 100, "R6 mid one short");
      do_pulse(K_HIGH, 5, 100, "R6 short high");
      // R3 / R4 / R5
      do_pulse(K_HIGH, ACT_C, 100, "R3 high at min");
      do_pulse(K_HIGH, BMIN_C - 1, 100, "R3 high below blow");
      do_pulse(K_HIGH, BMIN_C, 100, "R4 blow low edge");
      do_pulse(K_HIGH, BMAX_C, 100, "R4 blow high edge");
      do_pulse(K_HIGH, BMAX_C + 1, 100, "R5 high too long");
      do_pulse(K_STEP, 150, 100, "R3 mid then high");
      // R8
      do_pulse(K_VIOL, 150, 100, "R8 high without mid");
      // R7 gap boundary
      do_pulse(K_MID, 100, GAP_C - 1, "R2 mid before short gap");
      do_pulse(K_MID, 100, GAP_C, "R7 gap one short");
      do_pulse(K_MID, 100, 100, "R7 gap at min");
      // R9 spikes split a gap that is only long enough as a whole
      do_pulse(K_MID, 1, 45, "R9 mid spike ignored");
      do_pulse(K_HIGH, 1, 45, "R9 high spike ignored");
      do_pulse(K_MID, 100, 100, "R9 gap survives spikes");
      // random mix
      for (int n = 0; n < 40; n++) begin
         int kind, w, tail;
         kind = int'($urandom_range(0, 9));
         kind = (kind < 4) ? K_MID : (kind < 7) ? K_HIGH : (kind < 9) ? K_STEP : K_VIOL;
         w = int'($urandom_range(2, 450));
         if (kind == K_STEP && w < 10) kind = K_HIGH;
         tail = int'($urandom_range(30, 140));
         do_pulse(kind, w, tail, "R10 random pulse");
      end
      // R10 strobe shape
      chk(dbl == 0, "R10 strobe longer than one clock", dbl, 0);
      chk(during == 0, "R10 strobe while pin active", during, 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule